// File: doc/BRIEF.md
# Receive Error and Overrun Gate for a Serial Receiver FIFO

This block sits between the character-level output of an asynchronous serial receiver and a receive FIFO of `DEPTH` entries (16 by default). Each time the receiver finishes a character, the block decides what happens to it. The character may be pushed into the FIFO with its framing and parity tags attached. It may be dropped as an overrun because the FIFO has no free entry. It may also be ignored because reception is disabled or blocked.

Software reaches the control and status bits through a one-word register port:

- a read strobe arms the clear of any sticky flag it observes as 1;
- a later write of 0 to that flag then clears it.

An error-ignore control selects between two policies for characters with framing or parity errors:

- halt reception after the errored character;
- keep pushing characters and continue.

A standby input clears the sticky state synchronously, in the same way as reset.

The FIFO level is an input. The block counts its own push that is still in flight, so characters that arrive back to back are judged against the true occupancy.

Top module: `rx_fifo_err_ctrl`

## Requirements
- R1: A character that is accepted on `char_done` appears on the push port in the following cycle. `push_valid` is high for that one cycle, with `push_data` equal to the character and `push_fe`/`push_pe` equal to its framing and parity flags.
- R2: The FIFO counts as full when `fifo_level` plus a push issued in the previous cycle reaches `DEPTH`. A character that completes while the FIFO is full is never pushed.
- R3: A character that completes while the FIFO is full, with reception enabled and not blocked, sets the overrun flag. The overrun flag is bit 0 of `reg_rdata`, and it is set one cycle after the character.
- R4: While the overrun flag is 1, no character is pushed.
- R5: A write to the register clears a sticky flag only under two conditions: the written bit is 0, and a read (`reg_rd`) has returned that flag as 1 since the flag was last set. A write of 0 without such a read leaves the flag at 1, and a write of 1 has no effect on it. This applies to overrun (bit 0) and to receive error (bit 2).
- R6: Reset clears overrun, receive error and error-ignore. Standby clears overrun and receive error one cycle after it is asserted.
- R7: While `rx_en` is 0, completed characters are neither pushed nor counted as overruns, and the overrun flag keeps its value.
- R8: With error-ignore at 0 (bit 1 of the register), a character with a framing or parity error is still pushed with its tags, and it sets the receive-error flag (bit 2). Every later character is then dropped until software clears bit 2.
- R9: With error-ignore at 1, characters with errors are pushed with their tags and reception continues. The receive-error flag is still set, as status only.
- R10: `reg_rdata` reads back as {5'b0, receive error, error-ignore, overrun}, from bit 7 down to bit 0. A write updates error-ignore from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous clear of the sticky flags |
| rx_en | input | 1 | Receive enable |
| char_done | input | 1 | Receiver character-complete strobe |
| char_data | input | DATA_W | Received character |
| char_fe | input | 1 | Framing error on this character |
| char_pe | input | 1 | Parity error on this character |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| push_valid | output | 1 | Push one entry into the FIFO |
| push_data | output | DATA_W | Entry data |
| push_fe | output | 1 | Entry framing error tag |
| push_pe | output | 1 | Entry parity error tag |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
Every result is registered once. A push, an overrun, a receive-error flag and any clear of a flag all become visible on the ports in the cycle after the stimulus edge, and the register read data reflects the state at once. The bench drives inputs on the falling edge, holds them over exactly one rising edge and samples at the next falling edge, so each check lands in the first cycle where the result is due. Back-to-back characters at a level of 15 check the count of the in-flight push. Writes made without a prior read, and writes of 1, are each followed by a read-back of the flag.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_OVR = 0;
    localparam int BIT_EI  = 1;
    localparam int BIT_RXE = 2;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PUSH    = 2'd1,
        ACT_OVERRUN = 2'd2
    } rx_action_e;
endpackage

// File: rtl/rxfe_sticky_flag.sv
module rxfe_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_all,
    input  logic set_evt,
    input  logic rd_evt,
    input  logic wr_evt,
    input  logic wr_bit,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic armed;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_evt && st_q.flag)
            st_d.armed = 1'b1;
        if (wr_evt && !wr_bit && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (set_evt) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end
        if (clear_all) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/rxfe_admit.sv
module rxfe_admit #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                 char_done,
    input  logic                 rx_en,
    input  logic                 ovr,
    input  logic                 rxe,
    input  logic                 ei,
    input  logic [LVL_W-1:0]     fifo_level,
    input  logic                 push_pending,
    output rxfe_pkg::rx_action_e action
);
    import rxfe_pkg::*;

    localparam int SUM_W = LVL_W + 1;

    logic [SUM_W-1:0] occupied;
    logic             full;
    logic             blocked;

    always_comb begin
        occupied = SUM_W'(fifo_level) + SUM_W'(push_pending);
        full     = (occupied >= SUM_W'(DEPTH));
        blocked  = ovr || (rxe && !ei);
        action   = ACT_NONE;
        if (char_done && rx_en && !blocked)
            action = full ? ACT_OVERRUN : ACT_PUSH;
    end
endmodule

// File: rtl/rx_fifo_err_ctrl.sv
module rx_fifo_err_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              rx_en,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_fe,
    input  logic              char_pe,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_fe,
    output logic              push_pe,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    import rxfe_pkg::*;

    typedef struct packed {
        logic              ei;
        logic              pv;
        logic [DATA_W-1:0] pdata;
        logic              pfe;
        logic              ppe;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    rx_action_e action;
    logic       ovr_flag, rxe_flag;
    logic       set_ovr, set_rxe;

    rxfe_admit #(.DEPTH(DEPTH), .LVL_W(LVL_W)) admit_i (
        .char_done    (char_done),
        .rx_en        (rx_en),
        .ovr          (ovr_flag),
        .rxe          (rxe_flag),
        .ei           (ctl_q.ei),
        .fifo_level   (fifo_level),
        .push_pending (ctl_q.pv),
        .action       (action)
    );

    always_comb begin
        set_ovr = (action == ACT_OVERRUN);
        set_rxe = (action == ACT_PUSH) && (char_fe || char_pe);
    end

    rxfe_sticky_flag ovr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (standby),
        .set_evt   (set_ovr),
        .rd_evt    (reg_rd),
        .wr_evt    (reg_wr),
        .wr_bit    (reg_wdata[BIT_OVR]),
        .flag      (ovr_flag)
    );

    rxfe_sticky_flag rxe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (standby),
        .set_evt   (set_rxe),
        .rd_evt    (reg_rd),
        .wr_evt    (reg_wr),
        .wr_bit    (reg_wdata[BIT_RXE]),
        .flag      (rxe_flag)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.pv = 1'b0;
        if (action == ACT_PUSH) begin
            ctl_d.pv    = 1'b1;
            ctl_d.pdata = char_data;
            ctl_d.pfe   = char_fe;
            ctl_d.ppe   = char_pe;
        end
        if (reg_wr)
            ctl_d.ei = reg_wdata[BIT_EI];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[BIT_OVR] = ovr_flag;
        reg_rdata[BIT_EI]  = ctl_q.ei;
        reg_rdata[BIT_RXE] = rxe_flag;
    end

    assign push_valid = ctl_q.pv;
    assign push_data  = ctl_q.pdata;
    assign push_fe    = ctl_q.pfe;
    assign push_pe    = ctl_q.ppe;
endmodule

// File: rtl/rx_fifo_err_ctrl_chk.sv
module rx_fifo_err_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             rx_en,
    input logic             char_done,
    input logic [LVL_W-1:0] fifo_level,
    input logic             push_valid,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata
);
    logic [LVL_W:0] occ;
    assign occ = {1'b0, fifo_level} + {{LVL_W{1'b0}}, push_valid};

    a_r1_push_follows_char: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(char_done));

    a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && occ >= (LVL_W+1)'(DEPTH)) |=> !push_valid);

    a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_en && occ >= (LVL_W+1)'(DEPTH) && !reg_rdata[2] && !standby)
        |=> reg_rdata[0]);

    a_r4_blocked_by_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |=> !push_valid);

    a_r5_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && reg_rdata[0] && !standby) |=> reg_rdata[0]);

    a_r6_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!reg_rdata[0] && !reg_rdata[2]));

    a_r7_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !push_valid);

    a_r8_halt_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !reg_rdata[1]) |=> !push_valid);
endmodule

bind rx_fifo_err_ctrl rx_fifo_err_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .rx_en      (rx_en),
    .char_done  (char_done),
    .fifo_level (fifo_level),
    .push_valid (push_valid),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
);

// File: tb/rx_fifo_err_ctrl_tb_top.sv
module rx_fifo_err_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    logic             clk = 0;
    logic             rst_n = 0;
    logic             standby = 0;
    logic             rx_en = 1;
    logic             char_done = 0;
    logic [7:0]       char_data = 0;
    logic             char_fe = 0;
    logic             char_pe = 0;
    logic [LVL_W-1:0] fifo_level;
    logic             push_valid;
    logic [7:0]       push_data;
    logic             push_fe;
    logic             push_pe;
    logic             reg_rd = 0;
    logic             reg_wr = 0;
    logic [7:0]       reg_wdata = 0;
    logic [7:0]       reg_rdata;
    logic             drain = 0;
    logic             finished = 0;
    int               n_chk = 0;
    int               n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)          fifo_level <= '0;
        else if (drain)      fifo_level <= '0;
        else if (push_valid) fifo_level <= fifo_level + 1'b1;
    end

    rx_fifo_err_ctrl #(.DATA_W(8), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby), .rx_en(rx_en),
        .char_done(char_done), .char_data(char_data), .char_fe(char_fe),
        .char_pe(char_pe), .fifo_level(fifo_level), .push_valid(push_valid),
        .push_data(push_data), .push_fe(push_fe), .push_pe(push_pe),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FIFO check FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one character held over one rising edge; outputs sampled at the next falling edge
    task automatic send(input logic [7:0] d, input logic fe, input logic pe);
        @(negedge clk);
        char_done = 1; char_data = d; char_fe = fe; char_pe = pe;
        @(negedge clk);
        char_done = 0; char_fe = 0; char_pe = 0;
    endtask

    task automatic expect_push(input logic [7:0] d, input logic fe, input logic pe, input string req);
        chk(push_valid === 1'b1, req, push_valid, 1);
        chk(push_data === d, req, push_data, d);
        chk({push_fe, push_pe} === {fe, pe}, req, {push_fe, push_pe}, {fe, pe});
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1;
        v = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr_status(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_drain();
        @(negedge clk); drain = 1;
        @(negedge clk); drain = 0;
    endtask

    task automatic t_reset();
        chk(reg_rdata === 8'h00, "R6 reset state", reg_rdata, 0);
        chk(push_valid === 1'b0, "R6 no push at reset", push_valid, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 0, 0); expect_push(8'hA5, 0, 0, "R1 plain char");
        @(negedge clk);
        chk(push_valid === 1'b0, "R1 single-cycle push", push_valid, 0);
        send(8'h3C, 0, 0); expect_push(8'h3C, 0, 0, "R1 second char");
        chk(reg_rdata === 8'h00, "R10 clean status", reg_rdata, 0);
    endtask

    task automatic t_overrun();
        logic [7:0] s;
        do_drain();
        for (int i = 0; i < DEPTH - 1; i++) send(8'(i), 0, 0);
        // back-to-back pair at level 15: first pushed, second overruns
        @(negedge clk);
        char_done = 1; char_data = 8'hE1;
        @(negedge clk);
        char_data = 8'hE2;
        chk(push_valid === 1'b1 && push_data === 8'hE1, "R2 last slot filled", push_data, 8'hE1);
        @(negedge clk);
        char_done = 0;
        chk(push_valid === 1'b0, "R2 in-flight push counts as full", push_valid, 0);
        chk(reg_rdata[0] === 1'b1, "R3 overrun flag set", reg_rdata[0], 1);
        chk(fifo_level == LVL_W'(DEPTH), "R3 stored entries kept", fifo_level, DEPTH);
        do_drain();
        send(8'h55, 0, 0);
        chk(push_valid === 1'b0, "R4 blocked while overrun", push_valid, 0);
        wr_status(8'h00);
        @(negedge clk);
        chk(reg_rdata[0] === 1'b1, "R5 write 0 without read ignored", reg_rdata[0], 1);
        rd_status(s);
        chk(s[0] === 1'b1, "R5 read returns 1", s[0], 1);
        wr_status(8'h01);
        @(negedge clk);
        chk(reg_rdata[0] === 1'b1, "R5 write 1 ignored", reg_rdata[0], 1);
        wr_status(8'h00);
        chk(reg_rdata[0] === 1'b0, "R5 read then write 0 clears", reg_rdata[0], 0);
        send(8'h66, 0, 0); expect_push(8'h66, 0, 0, "R4 reception resumes");
    endtask

    task automatic t_rx_disable();
        do_drain();
        for (int i = 0; i < DEPTH; i++) send(8'(i), 0, 0);
        send(8'h77, 0, 0);
        chk(reg_rdata[0] === 1'b1, "R7 setup overrun", reg_rdata[0], 1);
        @(negedge clk); rx_en = 0;
        do_drain();
        send(8'h88, 0, 0);
        chk(push_valid === 1'b0, "R7 disabled no push", push_valid, 0);
        chk(reg_rdata[0] === 1'b1, "R7 overrun kept with rx_en low", reg_rdata[0], 1);
        @(negedge clk); standby = 1;
        @(negedge clk); standby = 0;
        chk(reg_rdata[0] === 1'b0, "R6 standby clears overrun", reg_rdata[0], 0);
        do_drain();
        for (int i = 0; i < DEPTH; i++) send(8'(i), 0, 0);
        send(8'h99, 0, 0);
        chk(reg_rdata[0] === 1'b0 && push_valid === 1'b0, "R7 no overrun while disabled", reg_rdata[0], 0);
        @(negedge clk); rx_en = 1;
        do_drain();
    endtask

    task automatic t_halt();
        logic [7:0] s;
        send(8'h12, 1, 0); expect_push(8'h12, 1, 0, "R8 errored char tagged");
        chk(reg_rdata === 8'h04, "R8 rx error set, R10 layout", reg_rdata, 8'h04);
        send(8'h34, 0, 0);
        chk(push_valid === 1'b0, "R8 halted after error", push_valid, 0);
        wr_status(8'h00);
        send(8'h35, 0, 0);
        chk(push_valid === 1'b0, "R8 halt kept without read", push_valid, 0);
        rd_status(s);
        wr_status(8'h00);
        chk(reg_rdata[2] === 1'b0, "R8 rx error cleared", reg_rdata[2], 0);
        send(8'h56, 0, 0); expect_push(8'h56, 0, 0, "R8 resumes after clear");
    endtask

    task automatic t_ignore();
        wr_status(8'h02);
        chk(reg_rdata === 8'h02, "R10 error-ignore readback", reg_rdata, 8'h02);
        send(8'hC1, 0, 1); expect_push(8'hC1, 0, 1, "R9 parity char pushed");
        send(8'hC2, 1, 1); expect_push(8'hC2, 1, 1, "R9 continues after error");
        send(8'hC3, 0, 0); expect_push(8'hC3, 0, 0, "R9 clean char after errors");
        chk(reg_rdata[2] === 1'b1, "R9 rx error status set", reg_rdata[2], 1);
        @(negedge clk); standby = 1;
        @(negedge clk); standby = 0;
        chk(reg_rdata === 8'h02, "R6 standby clears rx error keeps ignore", reg_rdata, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_basic();
        t_overrun();
        t_rx_disable();
        t_halt();
        t_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("Watchdog FAIL all actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule